// File: doc/BRIEF.md
# Board Status Panel Register Block

This block is a small register-mapped peripheral for a development board. A processor reaches it over a simple synchronous read/write bus with a 20-bit register offset and 32-bit data. Through it, software drives an 8-LED bar, an 8-character ASCII text buffer, a general-purpose output byte and a set of bit-bang I2C control registers. It can also request a system reset.

The text buffer can be loaded one character at a time. It can also be loaded from a single 32-bit write that becomes eight uppercase hexadecimal digits. Character 0 is the leftmost position and is presented on `disp_chars[7:0]`. The I2C input register returns the live data level of the attached serial memory, so software can bit-bang a transfer with no further hardware.

Top module: `board_panel_regs`

## Requirements
- R1: A write to offset 0x00010 loads the LED register from write data bits [7:0]; `led_o[i]` follows bit i, and a read of 0x00010 returns the value zero-extended.
- R2: A write to offset 0x00410 sets every character position k (0..7) to the uppercase ASCII hex digit of write data bits [31-4k:28-4k]. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46.
- R3: Character position registers lie at offset 0x418 + 8*k for k = 0..7. A write stores data bits [7:0] into character k (`disp_chars[8k+7:8k]`), and a read returns that byte zero-extended.
- R4: After reset, every character holds 0x20 (space), and the LED, general-purpose, I2C enable, I2C output, I2C select and soft-reset outputs are all zero.
- R5: A write to offset 0x00500 raises `soft_rst_req` for exactly one cycle, in the cycle after the write.
- R6: The register at 0x00A00 keeps data bits [7:0] (the GP output), 0x00B08 keeps bits [1:0] (the I2C enables), 0x00B10 keeps bits [1:0] with bit 1 driving SCL and bit 0 driving SDA, and 0x00B18 keeps bit 0 (the I2C select). Each reads back zero-extended.
- R7: A read of offset 0x00B00 returns bit 0 equal to the live `i2c_sda_i`, bit 1 equal to the stored SCL output bit, and all other bits zero.
- R8: A read of offset 0x00000 (switches) returns zero and raises no error.
- R9: An access to any other offset, including misaligned offsets inside the character window, reads as zero, changes no state, and raises `bus_err` in the following cycle for one cycle per access.
- R10: A write changes outputs only after the clock edge that samples it. Read data is combinational from the current offset and the registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Register offset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_err | output | 1 | Access to an undefined offset, one cycle later |
| led_o | output | 8 | LED bar |
| disp_chars | output | 64 | Eight ASCII characters, character 0 in bits [7:0] |
| gp_out | output | 8 | General-purpose output byte |
| i2c_scl_o | output | 1 | SCL drive level |
| i2c_sda_o | output | 1 | SDA drive level |
| i2c_oe_o | output | 2 | I2C output enables |
| i2c_sel_o | output | 1 | I2C select |
| i2c_sda_i | input | 1 | Live SDA level from the serial memory |
| soft_rst_req | output | 1 | System reset request pulse |

## Verification
The assertions assume that the strobes are single-cycle and are driven together with a stable offset and data. They also assume that `i2c_sda_i` changes only between reads, and that read data is used only in cycles where the read strobe is high. The bench drives each strobe for exactly one cycle, starting at the falling edge. It changes the SDA input only while no read is active. It probes undefined offsets, including a misaligned one inside the character window, only through ordinary reads and writes.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
    localparam int OFF_W = 20;

    localparam logic [OFF_W-1:0] OFF_SWITCH = 20'h00000;
    localparam logic [OFF_W-1:0] OFF_LED    = 20'h00010;
    localparam logic [OFF_W-1:0] OFF_WORD   = 20'h00410;
    localparam logic [OFF_W-1:0] OFF_CHAR0  = 20'h00418;
    localparam logic [OFF_W-1:0] OFF_SRST   = 20'h00500;
    localparam logic [OFF_W-1:0] OFF_GPOUT  = 20'h00A00;
    localparam logic [OFF_W-1:0] OFF_I2CIN  = 20'h00B00;
    localparam logic [OFF_W-1:0] OFF_I2COE  = 20'h00B08;
    localparam logic [OFF_W-1:0] OFF_I2COUT = 20'h00B10;
    localparam logic [OFF_W-1:0] OFF_I2CSEL = 20'h00B18;

    localparam logic [7:0] CHAR_BLANK = 8'h20;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SWITCH, SEL_LED, SEL_WORD, SEL_CHAR, SEL_SRST,
        SEL_GPOUT, SEL_I2CIN, SEL_I2COE, SEL_I2COUT, SEL_I2CSEL
    } reg_sel_e;

    // One nibble to its uppercase ASCII hex digit.
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'b0, n};
        else           return 8'h37 + {4'b0, n};
    endfunction
endpackage

// File: rtl/bpd_decode.sv
module bpd_decode
    import bpd_pkg::*;
#(
    parameter int N_CHARS = 8,
    parameter int IDX_W   = $clog2(N_CHARS)
) (
    input  logic [OFF_W-1:0] offset,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] char_idx
);
    localparam logic [OFF_W-1:0] CHAR_SPAN = OFF_W'(N_CHARS * 8);

    logic [OFF_W-1:0] rel;

    always_comb begin
        rel      = offset - OFF_CHAR0;
        char_idx = rel[3 +: IDX_W];
        sel      = SEL_NONE;
        if (rel < CHAR_SPAN && rel[2:0] == 3'b000) begin
            sel = SEL_CHAR;
        end else begin
            case (offset)
                OFF_SWITCH: sel = SEL_SWITCH;
                OFF_LED:    sel = SEL_LED;
                OFF_WORD:   sel = SEL_WORD;
                OFF_SRST:   sel = SEL_SRST;
                OFF_GPOUT:  sel = SEL_GPOUT;
                OFF_I2CIN:  sel = SEL_I2CIN;
                OFF_I2COE:  sel = SEL_I2COE;
                OFF_I2COUT: sel = SEL_I2COUT;
                OFF_I2CSEL: sel = SEL_I2CSEL;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/bpd_hexfmt.sv
module bpd_hexfmt
    import bpd_pkg::*;
#(
    parameter int N_CHARS = 8
) (
    input  logic [4*N_CHARS-1:0] word,
    output logic [8*N_CHARS-1:0] chars
);
    // Character 0 takes the most significant nibble.
    for (genvar g = 0; g < N_CHARS; g++) begin : g_digit
        assign chars[8*g +: 8] = nib_to_ascii(word[4*(N_CHARS-1-g) +: 4]);
    end
endmodule

// File: rtl/board_panel_regs.sv
module board_panel_regs
    import bpd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LED_W  = 8,
    parameter int GP_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OFF_W-1:0]      bus_addr,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_err,
    output logic [LED_W-1:0]      led_o,
    output logic [2*DATA_W-1:0]   disp_chars,
    output logic [GP_W-1:0]       gp_out,
    output logic                  i2c_scl_o,
    output logic                  i2c_sda_o,
    output logic [1:0]            i2c_oe_o,
    output logic                  i2c_sel_o,
    input  logic                  i2c_sda_i,
    output logic                  soft_rst_req
);
    localparam int N_CHARS = DATA_W / 4;
    localparam int IDX_W   = $clog2(N_CHARS);

    typedef struct packed {
        logic [LED_W-1:0]        led;
        logic [GP_W-1:0]         gp;
        logic [N_CHARS-1:0][7:0] chars;
        logic [1:0]              oe;
        logic [1:0]              io;   // bit 1 SCL, bit 0 SDA
        logic                    sel;
        logic                    srst;
        logic                    err;
    } state_t;

    state_t           st_d, st_q;
    reg_sel_e         sel;
    logic [IDX_W-1:0] char_idx;
    logic [8*N_CHARS-1:0] hex_chars;

    bpd_decode #(.N_CHARS(N_CHARS), .IDX_W(IDX_W)) u_dec (
        .offset   (bus_addr),
        .sel      (sel),
        .char_idx (char_idx)
    );

    bpd_hexfmt #(.N_CHARS(N_CHARS)) u_hex (
        .word  (bus_wdata),
        .chars (hex_chars)
    );

    always_comb begin
        st_d      = st_q;
        st_d.srst = 1'b0;
        st_d.err  = 1'b0;
        if (bus_wr_en) begin
            case (sel)
                SEL_LED:    st_d.led = bus_wdata[LED_W-1:0];
                SEL_WORD:   st_d.chars = hex_chars;
                SEL_CHAR:   st_d.chars[char_idx] = bus_wdata[7:0];
                SEL_SRST:   st_d.srst = 1'b1;
                SEL_GPOUT:  st_d.gp = bus_wdata[GP_W-1:0];
                SEL_I2COE:  st_d.oe = bus_wdata[1:0];
                SEL_I2COUT: st_d.io = bus_wdata[1:0];
                SEL_I2CSEL: st_d.sel = bus_wdata[0];
                SEL_NONE:   st_d.err = 1'b1;
                default:    ;
            endcase
        end
        if (bus_rd_en && sel == SEL_NONE) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.chars <= {N_CHARS{CHAR_BLANK}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_LED:    bus_rdata = DATA_W'(st_q.led);
            SEL_CHAR:   bus_rdata = DATA_W'(st_q.chars[char_idx]);
            SEL_GPOUT:  bus_rdata = DATA_W'(st_q.gp);
            SEL_I2CIN:  bus_rdata = DATA_W'({st_q.io[1], i2c_sda_i});
            SEL_I2COE:  bus_rdata = DATA_W'(st_q.oe);
            SEL_I2COUT: bus_rdata = DATA_W'(st_q.io);
            SEL_I2CSEL: bus_rdata = DATA_W'(st_q.sel);
            default:    bus_rdata = '0;
        endcase
    end

    assign led_o        = st_q.led;
    assign disp_chars   = st_q.chars;
    assign gp_out       = st_q.gp;
    assign i2c_scl_o    = st_q.io[1];
    assign i2c_sda_o    = st_q.io[0];
    assign i2c_oe_o     = st_q.oe;
    assign i2c_sel_o    = st_q.sel;
    assign soft_rst_req = st_q.srst;
    assign bus_err      = st_q.err;
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker
    import bpd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OFF_W-1:0] bus_addr,
    input logic             bus_wr_en,
    input logic             bus_rd_en,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             bus_err,
    input logic [7:0]       led_o,
    input logic [63:0]      disp_chars,
    input logic             i2c_scl_o,
    input logic             i2c_sda_i,
    input logic             soft_rst_req
);
    a_r1_led_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFF_LED) |=> led_o == $past(bus_wdata[7:0]));

    a_r2_word_hexdigit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFF_WORD) |=>
            ((disp_chars[7:0] >= 8'h30 && disp_chars[7:0] <= 8'h39) ||
             (disp_chars[7:0] >= 8'h41 && disp_chars[7:0] <= 8'h46)));

    a_r5_srst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> $past(bus_wr_en));

    a_r6_scl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFF_I2COUT) |=> i2c_scl_o == $past(bus_wdata[1]));

    a_r7_i2cin_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == OFF_I2CIN) |->
            (bus_rdata[0] == i2c_sda_i && bus_rdata[31:2] == 30'b0));

    a_r8_switch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == OFF_SWITCH) |-> bus_rdata == 32'b0);

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd_en || bus_wr_en));

    a_r9_no_err_on_led: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !bus_rd_en && bus_addr == OFF_LED) |=> !bus_err);
endmodule

bind board_panel_regs bpd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .led_o        (led_o),
    .disp_chars   (disp_chars),
    .i2c_scl_o    (i2c_scl_o),
    .i2c_sda_i    (i2c_sda_i),
    .soft_rst_req (soft_rst_req)
);

// File: tb/board_panel_regs_tb.sv
module board_panel_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  led_o;
    logic [63:0] disp_chars;
    logic [7:0]  gp_out;
    logic        i2c_scl_o, i2c_sda_o, i2c_sel_o;
    logic [1:0]  i2c_oe_o;
    logic        i2c_sda_i = 1'b0;
    logic        soft_rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic err_seen;

    always #4 clk = ~clk;

    board_panel_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .led_o(led_o), .disp_chars(disp_chars), .gp_out(gp_out),
        .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .i2c_oe_o(i2c_oe_o),
        .i2c_sel_o(i2c_sel_o), .i2c_sda_i(i2c_sda_i), .soft_rst_req(soft_rst_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One-cycle write; returns with the result visible, err_seen holds bus_err then.
    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        err_seen = bus_err;
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd_en = 1'b0;
        err_seen = bus_err;
    endtask

    function automatic logic [63:0] hex_text(input logic [31:0] v);
        string digits = "0123456789ABCDEF";
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = digits[v[31-4*k -: 4]];
        return r;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R4 chars", disp_chars, {8{8'h20}});
        chk("R4 leds", led_o, 0);
        chk("R4 gp/i2c", {gp_out, i2c_oe_o, i2c_scl_o, i2c_sda_o, i2c_sel_o}, 0);
        chk("R4 srst/err", {soft_rst_req, bus_err}, 0);
        rd(20'h00B10, d);
        chk("R4 i2cout read", d, 0);
    endtask

    task automatic t_led();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = 20'h00010; bus_wdata = 32'hABCD12F5; bus_wr_en = 1'b1;
        #1 chk("R10 led before edge", led_o, 0);
        @(negedge clk);
        bus_wr_en = 1'b0;
        chk("R1 led after edge", led_o, 8'hF5);
        chk("R9 no err on defined write", bus_err, 0);
        rd(20'h00010, d);
        chk("R1 led readback", d, 32'h000000F5);
    endtask

    task automatic t_word();
        wr(20'h00410, 32'h0123ABEF);
        chk("R2 word 0123ABEF", disp_chars, hex_text(32'h0123ABEF));
        wr(20'h00410, 32'hFEDC9876);
        chk("R2 word FEDC9876", disp_chars, hex_text(32'hFEDC9876));
        chk("R2 char0 is MS nibble", disp_chars[7:0], 8'h46);
    endtask

    task automatic t_chars();
        logic [31:0] d;
        logic [63:0] exp;
        for (int k = 0; k < 8; k++) begin
            wr(20'h00418 + 20'(8*k), 32'hFFFFFF61 + k);
            exp[8*k +: 8] = 8'h61 + 8'(k);
        end
        chk("R3 all positions", disp_chars, exp);
        rd(20'h00430, d);
        chk("R3 readback pos3", d, 32'h64);
        wr(20'h0041C, 32'h0000005A);
        chk("R9 misaligned char write ignored", disp_chars, exp);
        chk("R9 misaligned char err", err_seen, 1);
    endtask

    task automatic t_srst();
        wr(20'h00500, 32'h1);
        chk("R5 srst high", soft_rst_req, 1);
        @(negedge clk);
        chk("R5 srst one cycle", soft_rst_req, 0);
    endtask

    task automatic t_i2c_gp();
        logic [31:0] d;
        wr(20'h00B08, 32'hFFFFFFFF);
        chk("R6 oe", i2c_oe_o, 2'b11);
        rd(20'h00B08, d);
        chk("R6 oe readback", d, 3);
        wr(20'h00B10, 32'h6);
        chk("R6 scl/sda", {i2c_scl_o, i2c_sda_o}, 2'b10);
        wr(20'h00B18, 32'hF);
        chk("R6 sel", i2c_sel_o, 1);
        rd(20'h00B18, d);
        chk("R6 sel readback", d, 1);
        wr(20'h00A00, 32'h1A5);
        chk("R6 gp", gp_out, 8'hA5);
        rd(20'h00A00, d);
        chk("R6 gp readback", d, 32'hA5);
    endtask

    task automatic t_i2cin();
        logic [31:0] d;
        i2c_sda_i = 1'b1;
        rd(20'h00B00, d);
        chk("R7 sda1 scl1", d, 32'h3);
        i2c_sda_i = 1'b0;
        rd(20'h00B00, d);
        chk("R7 sda0 scl1", d, 32'h2);
        wr(20'h00B10, 32'h1);
        i2c_sda_i = 1'b1;
        rd(20'h00B00, d);
        chk("R7 sda1 scl0", d, 32'h1);
        i2c_sda_i = 1'b0;
    endtask

    task automatic t_switch();
        logic [31:0] d;
        rd(20'h00000, d);
        chk("R8 switch zero", d, 0);
        chk("R8 switch no err", err_seen, 0);
    endtask

    task automatic t_undef();
        logic [31:0] d;
        logic [63:0] chars_before;
        chars_before = disp_chars;
        rd(20'h7FFFC, d);
        chk("R9 undefined read zero", d, 0);
        chk("R9 err after read", err_seen, 1);
        @(negedge clk);
        chk("R9 err one cycle", bus_err, 0);
        wr(20'h7FFFC, 32'hFFFFFFFF);
        chk("R9 err after write", err_seen, 1);
        chk("R9 write ignored", {led_o, gp_out, i2c_oe_o, i2c_scl_o, i2c_sda_o, i2c_sel_o, soft_rst_req},
            {8'hF5, 8'hA5, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0});
        chk("R9 chars untouched", disp_chars, chars_before);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_led();
        t_word();
        t_chars();
        t_srst();
        t_i2c_gp();
        t_i2cin();
        t_switch();
        t_undef();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule